// File: doc/BRIEF.md
# Write buffer with read priority

This block sits between a write-through cache and the next memory level. Stores from the cache are held in a small first-in first-out queue. The processor side completes a store in one cycle unless every slot is occupied. The queue empties onto a single memory port using a valid/ready handshake. Read misses share that port and are given it ahead of queued stores. A read is not allowed onto the port while a pending store to the same word is still queued. The read is held until that store has left, so it can never fetch stale data from memory.

A starvation guard stops an endless run of reads from locking out the stores. After a fixed number of back-to-back read grants while stores wait, the oldest store takes the port for one transfer. The depth of the queue and the length of the read run are parameters.

Top module: `wbuf_rdprio`

## Requirements
- R1: After a synchronous reset the queue is empty, `wr_stall` is low, `mem_valid` is low and `rd_grant` is low while no read is requested.
- R2: A store offered while the queue is not full is taken in that same cycle with `wr_stall` low. Stores leave on the memory port in the order they were taken, each with `mem_we`=1 and its address, data and byte enables unchanged. A store reaches the port in the cycle after it is taken if the port is otherwise free.
- R3: With DEPTH stores queued and no store leaving in that cycle, `wr_stall` is high and the offered store is not taken. It is taken only once the stall drops, so it appears exactly once on the memory port.
- R4: On a full queue, a store leaving and a new store arriving in the same cycle are both carried out, and `wr_stall` stays low in that cycle.
- R5: A read whose word address matches no queued store and no store arriving in the same cycle is placed on the memory port with `mem_we`=0 and `mem_addr` equal to `rd_addr`, ahead of any queued store. `rd_grant` is high in the cycle the port accepts it.
- R6: Matching uses address bits 31:2 only. A read that matches a queued store, or a store offered in the same cycle, is not granted. Queued stores keep draining, and the read is granted only after every matching store has been accepted by memory.
- R7: After 8 consecutive read grants while at least one store is queued, the next cycle carries the oldest store on the port, even with a read still requesting it. The count restarts whenever a store leaves or the queue is empty.
- R8: A queued store is removed only in a cycle where `mem_valid`, `mem_we` and `mem_ready` are all high. While `mem_ready` is low, the same store stays on the port with unchanged address and data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | Cache offers a store |
| wr_addr | input | 32 | Store byte address |
| wr_data | input | 32 | Store data |
| wr_be | input | 4 | Store byte enables |
| wr_stall | output | 1 | Queue cannot take the offered store this cycle |
| rd_valid | input | 1 | Cache requests a read miss |
| rd_addr | input | 32 | Read byte address |
| rd_grant | output | 1 | Read accepted by memory this cycle |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 for a store, 0 for a read |
| mem_addr | output | 32 | Memory request address |
| mem_wdata | output | 32 | Store data to memory |
| mem_be | output | 4 | Byte enables (all ones for a read) |
| mem_ready | input | 1 | Memory accepts the request this cycle |

## Verification
Some rules are checked by assertions in every cycle. No read reaches the port while a store to its word is queued or arriving. A stalled store held by memory stays unchanged on the port. Slots are never overrun or read while empty. The run counter never skips or overshoots its limit. Other properties only the directed scenarios can show: the exact departure order of stores, that a store offered during a stall appears exactly once, that the forced store lands on precisely the ninth cycle of a read run, and the full sequence of port events around a hazard.

// File: rtl/wbuf_pkg.sv
// Package: shared widths and types for the write buffer.
// Assumes a 32-bit byte-addressed bus with one byte enable per data byte.
package wbuf_pkg;
    localparam int unsigned ADDR_W   = 32;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned BE_W     = DATA_W / 8;
    localparam int unsigned WORD_LSB = $clog2(BE_W);

    // One queued store.
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [BE_W-1:0]   be;
    } wb_entry_t;

    // Owner of the memory port in a cycle.
    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_READ  = 2'd1,
        BUS_WRITE = 2'd2
    } bus_sel_e;
endpackage

// File: rtl/wbuf_fifo.sv
// Module: circular store queue with a valid bit per slot.
// Exposes every slot's valid bit and address for hazard matching.
// Assumes the caller never pushes into a full queue unless it also pops.
module wbuf_fifo
    import wbuf_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  wb_entry_t                    push_entry,
    input  logic                         pop,
    output wb_entry_t                    head_entry,
    output logic                         empty,
    output logic                         full,
    output logic [DEPTH-1:0]             slot_vld,
    output logic [DEPTH-1:0][ADDR_W-1:0] slot_addr
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    wb_entry_t         slots [DEPTH];
    logic [DEPTH-1:0]  vld_q;
    logic [PW-1:0]     wptr_q;
    logic [PW-1:0]     rptr_q;

    assign empty      = ~|vld_q;
    assign full       = &vld_q;
    assign head_entry = slots[rptr_q];
    assign slot_vld   = vld_q;

    // Publish each slot's address for the hazard comparators.
    for (genvar i = 0; i < DEPTH; i++) begin : g_addr
        assign slot_addr[i] = slots[i].addr;
    end

    // Advance write and read pointers with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
        end else begin
            if (push) wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
            if (pop)  rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
        end
    end

    // Per-slot valid bits: clear on pop, then set on push (same slot when full).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            logic [DEPTH-1:0] nxt;
            nxt = vld_q;
            if (pop)  nxt[rptr_q] = 1'b0;
            if (push) nxt[wptr_q] = 1'b1;
            vld_q <= nxt;
        end
    end

    // Store payload into the slot under the write pointer.
    always_ff @(posedge clk) begin
        if (push) slots[wptr_q] <= push_entry;
    end

    // R3: a push into a full queue must be paired with a pop.
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |-> pop);

    // R8: nothing leaves an empty queue.
    a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/wbuf_hazard.sv
// Module: read-after-write hazard detector.
// Compares a read's word address against every valid slot and the store
// arriving in the same cycle. The byte offset bits are ignored.
module wbuf_hazard
    import wbuf_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic                         rd_valid,
    input  logic [ADDR_W-1:0]            rd_addr,
    input  logic [DEPTH-1:0]             slot_vld,
    input  logic [DEPTH-1:0][ADDR_W-1:0] slot_addr,
    input  logic                         in_valid,
    input  logic [ADDR_W-1:0]            in_addr,
    output logic                         hazard
);
    localparam logic [ADDR_W-1:0] WORD_MASK = ~((ADDR_W'(1) << WORD_LSB) - 1'b1);

    logic [DEPTH-1:0] slot_hit;
    logic             in_hit;

    // One comparator per queue slot.
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign slot_hit[i] = slot_vld[i] &&
                             (((rd_addr ^ slot_addr[i]) & WORD_MASK) == '0);
    end

    // Comparator for the store entering the queue this cycle.
    assign in_hit = in_valid && (((rd_addr ^ in_addr) & WORD_MASK) == '0);

    assign hazard = rd_valid && (in_hit || (|slot_hit));
endmodule

// File: rtl/wbuf_arbiter.sv
// Module: memory port arbiter with read priority and a starvation guard.
// Reads win unless hazarded or the run counter has hit its limit while
// stores wait. The counter counts read grants made with a non-empty queue.
module wbuf_arbiter
    import wbuf_pkg::*;
#(
    parameter int unsigned STARVE_LIMIT = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     rd_valid,
    input  logic     hazard,
    input  logic     wb_empty,
    input  logic     mem_ready,
    output bus_sel_e sel,
    output logic     rd_accept,
    output logic     wr_accept
);
    localparam int unsigned CW = $clog2(STARVE_LIMIT + 1);
    localparam logic [CW-1:0] LIMIT = CW'(STARVE_LIMIT);

    logic [CW-1:0] run_q;
    logic          force_wr;

    assign force_wr = !wb_empty && (run_q == LIMIT);

    // Choose the port owner for this cycle.
    always_comb begin
        if (rd_valid && !hazard && !force_wr) sel = BUS_READ;
        else if (!wb_empty)                   sel = BUS_WRITE;
        else                                  sel = BUS_IDLE;
    end

    assign rd_accept = (sel == BUS_READ)  && mem_ready;
    assign wr_accept = (sel == BUS_WRITE) && mem_ready;

    // Count read grants that pass over waiting stores; saturate at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (wb_empty || wr_accept) begin
            run_q <= '0;
        end else if (rd_accept && run_q < LIMIT) begin
            run_q <= run_q + 1'b1;
        end
    end

    // R5: an eligible read loses the port only when the run limit is reached.
    a_r5_read_first: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !hazard && sel == BUS_WRITE) |-> (run_q == LIMIT));

    // R7: the run counter moves by one step or restarts, never jumps.
    a_r7_run_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q != $past(run_q)) |-> (run_q == '0 || run_q == $past(run_q) + 1'b1));

    // R7: the counter never passes its limit.
    a_r7_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= LIMIT);
endmodule

// File: rtl/wbuf_rdprio.sv
// Module: top of the write buffer with read priority.
// Queues stores from a write-through cache and drains them to one memory
// port shared with read misses; reads go first unless they hit a queued
// store or the starvation guard fires. Assumes memory holds a request
// only while mem_ready is low; the request may change when ownership moves.
module wbuf_rdprio
    import wbuf_pkg::*;
#(
    parameter int unsigned DEPTH        = 4,
    parameter int unsigned STARVE_LIMIT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BE_W-1:0]   wr_be,
    output logic              wr_stall,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_grant,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [BE_W-1:0]   mem_be,
    input  logic              mem_ready
);
    wb_entry_t                    in_entry;
    wb_entry_t                    head;
    logic                         q_empty;
    logic                         q_full;
    logic [DEPTH-1:0]             slot_vld;
    logic [DEPTH-1:0][ADDR_W-1:0] slot_addr;
    logic                         push;
    logic                         hazard;
    bus_sel_e                     sel;
    logic                         rd_accept;
    logic                         wr_accept;

    assign in_entry = '{addr: wr_addr, data: wr_data, be: wr_be};
    assign wr_stall = q_full && !wr_accept;
    assign push     = wr_valid && !wr_stall;
    assign rd_grant = rd_accept;

    wbuf_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_entry (in_entry),
        .pop        (wr_accept),
        .head_entry (head),
        .empty      (q_empty),
        .full       (q_full),
        .slot_vld   (slot_vld),
        .slot_addr  (slot_addr)
    );

    wbuf_hazard #(.DEPTH(DEPTH)) u_hazard (
        .rd_valid  (rd_valid),
        .rd_addr   (rd_addr),
        .slot_vld  (slot_vld),
        .slot_addr (slot_addr),
        .in_valid  (wr_valid),
        .in_addr   (wr_addr),
        .hazard    (hazard)
    );

    wbuf_arbiter #(.STARVE_LIMIT(STARVE_LIMIT)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_valid  (rd_valid),
        .hazard    (hazard),
        .wb_empty  (q_empty),
        .mem_ready (mem_ready),
        .sel       (sel),
        .rd_accept (rd_accept),
        .wr_accept (wr_accept)
    );

    // Steer the selected request onto the memory port.
    always_comb begin
        mem_valid = (sel != BUS_IDLE);
        mem_we    = (sel == BUS_WRITE);
        mem_addr  = (sel == BUS_READ) ? rd_addr : head.addr;
        mem_wdata = head.data;
        mem_be    = (sel == BUS_READ) ? '1 : head.be;
    end

    // Checker-only view: does the port's read address hit any pending store?
    logic stale_hit;
    always_comb begin
        stale_hit = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (slot_vld[i] && slot_addr[i][ADDR_W-1:WORD_LSB] == mem_addr[ADDR_W-1:WORD_LSB])
                stale_hit = 1'b1;
        end
        if (wr_valid && wr_addr[ADDR_W-1:WORD_LSB] == mem_addr[ADDR_W-1:WORD_LSB])
            stale_hit = 1'b1;
    end

    // R6: a read on the port never overlaps a pending store's word.
    a_r6_no_stale_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_we) |-> !stale_hit);

    // R8: a store held by memory stays unchanged if it still owns the port.
    a_r8_hold_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_we && !mem_ready) |=>
        (mem_valid && (!mem_we || ($stable(mem_addr) && $stable(mem_wdata)))));

    // R1: leaving reset the queue is empty, so no stall is signalled.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> !wr_stall);
endmodule

// File: tb/sim_wbuf_rdprio.sv
// Directed bench: one task per scenario, each checking its own results.
module sim_wbuf_rdprio;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_valid;
    logic [31:0] wr_addr;
    logic [31:0] wr_data;
    logic [3:0]  wr_be;
    logic        wr_stall;
    logic        rd_valid;
    logic [31:0] rd_addr;
    logic        rd_grant;
    logic        mem_valid;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_be;
    logic        mem_ready;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // Log of every request accepted on the memory port.
    logic        ev_we   [0:255];
    logic [31:0] ev_addr [0:255];
    logic [31:0] ev_data [0:255];
    logic [3:0]  ev_be   [0:255];
    int          ev_n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wbuf_rdprio u0 (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
        .wr_stall(wr_stall),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_grant(rd_grant),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ready(mem_ready)
    );

    // Memory model: record each accepted request.
    always @(posedge clk) begin
        if (rst_n && mem_valid && mem_ready && ev_n < 256) begin
            ev_we[ev_n]   <= mem_we;
            ev_addr[ev_n] <= mem_addr;
            ev_data[ev_n] <= mem_wdata;
            ev_be[ev_n]   <= mem_be;
            ev_n          <= ev_n + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_ev(input string req, input int idx, input logic we,
                          input logic [31:0] addr, input logic [31:0] data);
        chk({req, " event kind"}, 32'(ev_we[idx]), 32'(we));
        chk({req, " event addr"}, ev_addr[idx], addr);
        if (we) chk({req, " event data"}, ev_data[idx], data);
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle();
        wr_valid = 0; rd_valid = 0;
    endtask

    task automatic put_write(input logic [31:0] a, input logic [31:0] d, input logic [3:0] b);
        wr_valid = 1; wr_addr = a; wr_data = d; wr_be = b;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // R1: state right after reset.
    task automatic t_reset();
        rst_n = 0; idle(); mem_ready = 0;
        wr_addr = 0; wr_data = 0; wr_be = 0; rd_addr = 0;
        repeat (3) tick();
        rst_n = 1;
        #1;
        chk("R1 stall", 32'(wr_stall), 0);
        chk("R1 mem_valid", 32'(mem_valid), 0);
        chk("R1 rd_grant", 32'(rd_grant), 0);
        tick();
    endtask

    // R2: one store, taken at once and sent next cycle with its fields.
    task automatic t_single_write();
        int base = ev_n;
        mem_ready = 1;
        put_write(32'h0000_1000, 32'hA5A5_0001, 4'b0011);
        #1 chk("R2 no stall", 32'(wr_stall), 0);
        tick(); idle();
        #1;
        chk("R2 valid", 32'(mem_valid), 1);
        chk("R2 we", 32'(mem_we), 1);
        chk("R2 addr", mem_addr, 32'h0000_1000);
        chk("R2 data", mem_wdata, 32'hA5A5_0001);
        chk("R2 be", 32'(mem_be), 32'h3);
        tick();
        chk("R2 count", 32'(ev_n - base), 1);
        #1 chk("R2 port idle", 32'(mem_valid), 0);
    endtask

    // R3, R4, R2: fill, stall, simultaneous push and pop, order out.
    task automatic t_fill();
        int base = ev_n;
        mem_ready = 0;
        for (int i = 0; i < 4; i++) begin
            put_write(32'h2000 + 4*i, 32'hD000 + i, 4'hF);
            #1 chk("R2 fill no stall", 32'(wr_stall), 0);
            tick();
        end
        put_write(32'h2010, 32'hD004, 4'hF);
        #1 chk("R3 stall when full", 32'(wr_stall), 1);
        tick();
        #1 chk("R3 still stalled", 32'(wr_stall), 1);
        chk("R3 head held", mem_addr, 32'h2000);
        tick();
        mem_ready = 1;
        #1;
        chk("R4 no stall on drain", 32'(wr_stall), 0);
        chk("R4 head leaving", mem_addr, 32'h2000);
        tick(); idle();
        repeat (6) tick();
        chk("R3 taken once", 32'(ev_n - base), 5);
        for (int i = 0; i < 5; i++)
            chk_ev("R2 order", base + i, 1'b1, 32'h2000 + 4*i, 32'hD000 + i);
    endtask

    // R5: read jumps ahead of queued stores.
    task automatic t_read_priority();
        int base = ev_n;
        mem_ready = 0;
        put_write(32'h3000, 32'h11, 4'hF); tick();
        put_write(32'h3004, 32'h22, 4'hF); tick();
        idle();
        rd_valid = 1; rd_addr = 32'h4000; mem_ready = 1;
        #1;
        chk("R5 grant", 32'(rd_grant), 1);
        chk("R5 read kind", 32'(mem_we), 0);
        chk("R5 read addr", mem_addr, 32'h4000);
        tick(); idle();
        repeat (4) tick();
        chk("R5 count", 32'(ev_n - base), 3);
        chk_ev("R5 first", base, 1'b0, 32'h4000, 0);
        chk_ev("R5 then", base + 1, 1'b1, 32'h3000, 32'h11);
        chk_ev("R5 then", base + 2, 1'b1, 32'h3004, 32'h22);
    endtask

    // R6: reads matching queued or arriving stores wait for them.
    task automatic t_hazard();
        int base = ev_n;
        mem_ready = 0;
        put_write(32'h5000, 32'h33, 4'hF); tick();
        put_write(32'h5004, 32'h44, 4'h1); tick();
        idle();
        rd_valid = 1; rd_addr = 32'h5006; mem_ready = 1;
        #1;
        chk("R6 blocked", 32'(rd_grant), 0);
        chk("R6 drain first", mem_addr, 32'h5000);
        tick();
        #1;
        chk("R6 still blocked", 32'(rd_grant), 0);
        chk("R6 drain match", mem_addr, 32'h5004);
        tick();
        #1 chk("R6 released", 32'(rd_grant), 1);
        tick(); idle();
        chk("R6 count", 32'(ev_n - base), 3);
        chk_ev("R6 seq", base + 2, 1'b0, 32'h5006, 0);
        // Same-cycle store to the read's word.
        base = ev_n;
        put_write(32'h6000, 32'h55, 4'hF);
        rd_valid = 1; rd_addr = 32'h6000;
        #1 chk("R6 arriving blocks", 32'(rd_grant), 0);
        tick(); wr_valid = 0;
        #1 chk("R6 queued blocks", 32'(rd_grant), 0);
        tick();
        #1 chk("R6 after drain", 32'(rd_grant), 1);
        tick(); idle();
        chk_ev("R6 store first", base, 1'b1, 32'h6000, 32'h55);
        chk_ev("R6 read after", base + 1, 1'b0, 32'h6000, 0);
    endtask

    // R7: eight read grants, then the queued store is forced through.
    task automatic t_starve();
        int reads = 0;
        int wpos  = -1;
        mem_ready = 0;
        put_write(32'h8000, 32'h66, 4'hF); tick();
        idle();
        rd_valid = 1; rd_addr = 32'h9000; mem_ready = 1;
        for (int c = 0; c < 12; c++) begin
            #1;
            if (rd_grant) reads++;
            else if (mem_valid && mem_we && wpos < 0) wpos = c;
            tick();
        end
        idle();
        chk("R7 forced slot", 32'(wpos), 8);
        chk("R7 read grants", 32'(reads), 11);
    endtask

    // R8: store held while memory is not ready, removed on acceptance.
    task automatic t_backpressure();
        int base = ev_n;
        mem_ready = 0;
        put_write(32'hA000, 32'hCAFE, 4'hF); tick();
        idle();
        for (int k = 0; k < 3; k++) begin
            #1;
            chk("R8 held valid", 32'(mem_valid && mem_we), 1);
            chk("R8 held addr", mem_addr, 32'hA000);
            chk("R8 held data", mem_wdata, 32'hCAFE);
            tick();
        end
        chk("R8 not removed", 32'(ev_n - base), 0);
        mem_ready = 1;
        tick();
        chk("R8 removed once", 32'(ev_n - base), 1);
        #1 chk("R8 empty after", 32'(mem_valid), 0);
    endtask

    initial begin
        t_reset();
        t_single_write();
        t_fill();
        t_read_priority();
        t_hazard();
        t_starve();
        t_backpressure();
        tick();
        done = 1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG);
            summary();
            $finish;
        end
    end
endmodule